// File: doc/BRIEF.md
# Elevator Car Unit Controller

This block steers a single elevator car toward one requested floor. Each clock edge it compares the requested floor with the floor the car is currently at. It then commands the car to climb, to descend, or to stop with the door open. On arrival the door is held open for a minimum number of one-second ticks, and it stays open after that for as long as the request still names the current floor. The door command is never raised while a motion command is active.

A fire alarm overrides normal service. While the alarm is raised the car goes down with its door shut until it reaches floor 1, then opens the door there. Normal service comes back only when the alarm has dropped and the emergency sequence has finished, meaning the car stands at floor 1 with the door open. Service then always restarts in the idle state.

Normal-service states are Idle, GoingUp, GoingDn and DoorOpen. Emergency states are FireDescend and FireOpen. A mode register selects which group drives the outputs. Named transitions:
- Idle→GoingUp when req > floor; Idle→GoingDn when req < floor.
- GoingUp→DoorOpen when req ≤ floor; GoingDn→DoorOpen when req ≥ floor.
- DoorOpen→Idle when the dwell counter reaches its limit.
- any normal state→FireDescend (floor > 1) or FireOpen (floor ≤ 1) when the alarm is raised.
- FireDescend→FireOpen when floor ≤ 1.
- FireOpen→Idle when the alarm is low.

Top module: `lift_unit_ctrl`

## Requirements
- R1: A synchronous reset puts the controller in normal-mode Idle. The first cycle after reset shows go_up=0, go_down=0, door_open=1, dwell_start=0.
- R2: In Idle the outputs are {go_up,go_down,door_open,dwell_start}=0010. Idle moves to GoingUp on the next edge if req_floor > cur_floor, to GoingDn if req_floor < cur_floor, and stays in Idle if they are equal.
- R3: GoingUp drives 1000 and is held while req_floor > cur_floor, moving to DoorOpen otherwise. GoingDn drives 0100 and is held while req_floor < cur_floor, moving to DoorOpen otherwise.
- R4: DoorOpen drives 0011. It counts sec_tick pulses and returns to Idle on the edge after DWELL_SEC pulses have been counted, whatever the request does in between.
- R5: door_open is never 1 in a cycle in which go_up or go_down is 1.
- R6: A fire_alarm sampled high in any normal state enters fire mode on that edge. Fire mode drives 0100 while cur_floor > 1 and 0010 once cur_floor ≤ 1. If the alarm is raised at floor 1 or below, the door opens with no downward cycle.
- R7: Fire mode is left only on an edge where fire_alarm is low and the door-open emergency state has been reached. Dropping the alarm during the descent does not end the emergency. The first normal state afterwards is Idle.
- R8: sec_tick pulses outside DoorOpen are ignored: the dwell count starts from zero on every entry to DoorOpen. With a tick every cycle, DoorOpen therefore lasts exactly DWELL_SEC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_floor | input | FLOOR_W | Requested floor number |
| cur_floor | input | FLOOR_W | Floor the car is currently at |
| fire_alarm | input | 1 | Fire emergency flag |
| sec_tick | input | 1 | One-cycle pulse per second |
| go_up | output | 1 | Climb command |
| go_down | output | 1 | Descend command |
| door_open | output | 1 | Door open command |
| dwell_start | output | 1 | Door dwell timer running |

## Verification
Every output is a Moore function of registered state. A condition present at the inputs at one rising edge is therefore visible on the outputs right after that edge, one cycle later, with no combinational path from input to output. The bench updates a behavioural model on each rising edge from the same inputs and compares all four outputs at the following falling edge, so each result is checked in the cycle in which it is due. Dwell length is checked by counting consecutive cycles of dwell_start at the ports, and the fire entry and exit checks sample exactly one and two edges after the alarm changes.

// File: rtl/lift_pkg.sv
package lift_pkg;

    typedef enum logic [1:0] {
        N_IDLE = 2'd0,
        N_UP   = 2'd1,
        N_DN   = 2'd2,
        N_DOOR = 2'd3
    } norm_st_t;

    typedef enum logic {
        F_DESCEND = 1'b0,
        F_OPEN    = 1'b1
    } fire_st_t;

    typedef enum logic {
        M_NORMAL = 1'b0,
        M_FIRE   = 1'b1
    } mode_t;

    typedef struct packed {
        logic up;
        logic dn;
        logic open;
        logic tstart;
    } car_cmd_t;

    localparam car_cmd_t CMD_IDLE = '{up: 1'b0, dn: 1'b0, open: 1'b1, tstart: 1'b0};
    localparam car_cmd_t CMD_UP   = '{up: 1'b1, dn: 1'b0, open: 1'b0, tstart: 1'b0};
    localparam car_cmd_t CMD_DN   = '{up: 1'b0, dn: 1'b1, open: 1'b0, tstart: 1'b0};
    localparam car_cmd_t CMD_DOOR = '{up: 1'b0, dn: 1'b0, open: 1'b1, tstart: 1'b1};

endpackage

// File: rtl/lift_dwell_timer.sv
module lift_dwell_timer #(
    parameter int DWELL_SEC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(DWELL_SEC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DWELL_SEC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIMIT);

    // R8: count restarts from zero whenever the door dwell is not running
    a_r8_clear_outside_door: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == '0);

    // R4: counter never passes the dwell limit
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

    // R4: each tick inside the dwell advances the count by one
    a_r4_tick_step: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/lift_normal_fsm.sv
module lift_normal_fsm
    import lift_pkg::*;
#(
    parameter int FLOOR_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic [FLOOR_W-1:0] req,
    input  logic [FLOOR_W-1:0] floor,
    input  logic               dwell_done,
    output norm_st_t           st,
    output car_cmd_t           cmd
);
    norm_st_t st_q, st_d;
    logic above, below;

    assign above = (req > floor);
    assign below = (req < floor);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            N_IDLE: begin
                if (above)      st_d = N_UP;
                else if (below) st_d = N_DN;
                else            st_d = N_IDLE;
            end
            N_UP:   st_d = above ? N_UP : N_DOOR;
            N_DN:   st_d = below ? N_DN : N_DOOR;
            N_DOOR: st_d = dwell_done ? N_IDLE : N_DOOR;
            default: st_d = N_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || hold) st_q <= N_IDLE;
        else             st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            N_IDLE:  cmd = CMD_IDLE;
            N_UP:    cmd = CMD_UP;
            N_DN:    cmd = CMD_DN;
            N_DOOR:  cmd = CMD_DOOR;
            default: cmd = CMD_IDLE;
        endcase
    end

    assign st = st_q;

    // R2: idle with a higher request starts climbing
    a_r2_idle_to_up: assert property (@(posedge clk) disable iff (rst)
        (!hold && st_q == N_IDLE && req > floor) |=> st_q == N_UP);

    // R2: idle with a lower request starts descending
    a_r2_idle_to_dn: assert property (@(posedge clk) disable iff (rst)
        (!hold && st_q == N_IDLE && req < floor) |=> st_q == N_DN);

    // R3: arrival while climbing opens the door
    a_r3_up_arrive: assert property (@(posedge clk) disable iff (rst)
        (!hold && st_q == N_UP && !(req > floor)) |=> st_q == N_DOOR);

    // R4: door stays open until the dwell has elapsed
    a_r4_min_dwell: assert property (@(posedge clk) disable iff (rst)
        (!hold && st_q == N_DOOR && !dwell_done) |=> st_q == N_DOOR);

endmodule

// File: rtl/lift_fire_fsm.sv
module lift_fire_fsm
    import lift_pkg::*;
#(
    parameter int FLOOR_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enter,
    input  logic [FLOOR_W-1:0] floor,
    output logic               at_ground_open,
    output car_cmd_t           cmd
);
    localparam logic [FLOOR_W-1:0] GROUND = FLOOR_W'(1);

    fire_st_t st_q, st_d;
    logic above_ground;

    assign above_ground = (floor > GROUND);

    always_comb begin
        st_d = st_q;
        if (enter) begin
            st_d = above_ground ? F_DESCEND : F_OPEN;
        end else begin
            unique case (st_q)
                F_DESCEND: st_d = above_ground ? F_DESCEND : F_OPEN;
                F_OPEN:    st_d = F_OPEN;
                default:   st_d = F_DESCEND;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= F_DESCEND;
        else     st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            F_DESCEND: cmd = CMD_DN;
            F_OPEN:    cmd = CMD_IDLE;
            default:   cmd = CMD_DN;
        endcase
    end

    assign at_ground_open = (st_q == F_OPEN);

    // R6: once the emergency door is open it stays open until re-entry
    a_r6_open_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q == F_OPEN && !enter) |=> st_q == F_OPEN);

    // R6: descent continues while above floor 1
    a_r6_keep_descending: assert property (@(posedge clk) disable iff (rst)
        (st_q == F_DESCEND && !enter && above_ground) |=> st_q == F_DESCEND);

endmodule

// File: rtl/lift_unit_ctrl.sv
module lift_unit_ctrl
    import lift_pkg::*;
#(
    parameter int FLOOR_W   = 4,
    parameter int DWELL_SEC = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FLOOR_W-1:0] req_floor,
    input  logic [FLOOR_W-1:0] cur_floor,
    input  logic               fire_alarm,
    input  logic               sec_tick,
    output logic               go_up,
    output logic               go_down,
    output logic               door_open,
    output logic               dwell_start
);
    mode_t    mode_q, mode_d;
    norm_st_t n_st;
    car_cmd_t n_cmd, f_cmd, cmd;
    logic     dwell_done, fire_done, fire_enter, norm_hold;

    assign fire_enter = (mode_q == M_NORMAL) && fire_alarm;
    assign norm_hold  = (mode_q == M_FIRE) || fire_alarm;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            M_NORMAL: if (fire_alarm)               mode_d = M_FIRE;
            M_FIRE:   if (fire_done && !fire_alarm) mode_d = M_NORMAL;
            default:                                mode_d = M_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= M_NORMAL;
        else     mode_q <= mode_d;
    end

    lift_normal_fsm #(.FLOOR_W(FLOOR_W)) u_norm (
        .clk        (clk),
        .rst        (rst),
        .hold       (norm_hold),
        .req        (req_floor),
        .floor      (cur_floor),
        .dwell_done (dwell_done),
        .st         (n_st),
        .cmd        (n_cmd)
    );

    lift_fire_fsm #(.FLOOR_W(FLOOR_W)) u_fire (
        .clk            (clk),
        .rst            (rst),
        .enter          (fire_enter),
        .floor          (cur_floor),
        .at_ground_open (fire_done),
        .cmd            (f_cmd)
    );

    lift_dwell_timer #(.DWELL_SEC(DWELL_SEC)) u_dwell (
        .clk  (clk),
        .rst  (rst),
        .run  (cmd.tstart),
        .tick (sec_tick),
        .done (dwell_done)
    );

    always_comb begin
        unique case (mode_q)
            M_NORMAL: cmd = n_cmd;
            M_FIRE:   cmd = f_cmd;
            default:  cmd = CMD_IDLE;
        endcase
    end

    assign go_up       = cmd.up;
    assign go_down     = cmd.dn;
    assign door_open   = cmd.open;
    assign dwell_start = cmd.tstart;

    // R5: door never open while the car is commanded to move
    a_r5_no_open_moving: assert property (@(posedge clk) disable iff (rst)
        door_open |-> !(go_up || go_down));

    // R5: at most one motion command at a time
    a_r5_single_motion: assert property (@(posedge clk) disable iff (rst)
        $onehot0({go_up, go_down}));

    // R6: an alarm in normal service preempts on the next edge
    a_r6_preempt: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_NORMAL && fire_alarm) |=> mode_q == M_FIRE);

    // R7: fire mode is held until the alarm is low and the sequence is done
    a_r7_hold_fire: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_FIRE && !(fire_done && !fire_alarm)) |=> mode_q == M_FIRE);

    // R7: normal service resumes in Idle
    a_r7_resume_idle: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_FIRE && fire_done && !fire_alarm) |=> (mode_q == M_NORMAL && n_st == N_IDLE));

endmodule

// File: tb/sim_lift_unit_ctrl.sv
module sim_lift_unit_ctrl;
    localparam int FW = 4;
    localparam int DW = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [FW-1:0] req_floor = 4'd2;
    logic [FW-1:0] cur_floor = 4'd2;
    logic fire_alarm = 1'b0;
    logic sec_tick = 1'b0;
    logic go_up, go_down, door_open, dwell_start;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    bit chk_on = 1'b0;
    bit plant_on = 1'b0;
    int tick_every = 1;
    int tick_ph = 0;
    int plant_cnt = 0;

    // behavioural reference: mode 0 normal / 1 fire; st 0 idle,1 up,2 dn,3 door; fs 0 descend,1 open
    int m_mode = 0, m_st = 0, m_fs = 0, m_cnt = 0;
    int run_len = 0, last_run = 0;

    always #10 clk = ~clk;

    lift_unit_ctrl #(.FLOOR_W(FW), .DWELL_SEC(DW)) u0 (
        .clk(clk), .rst(rst), .req_floor(req_floor), .cur_floor(cur_floor),
        .fire_alarm(fire_alarm), .sec_tick(sec_tick),
        .go_up(go_up), .go_down(go_down), .door_open(door_open), .dwell_start(dwell_start)
    );

    function automatic logic [3:0] model_out();
        if (m_mode == 1) return (m_fs == 1) ? 4'b0010 : 4'b0100;
        case (m_st)
            1: return 4'b1000;
            2: return 4'b0100;
            3: return 4'b0011;
            default: return 4'b0010;
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_st = 0; m_fs = 0; m_cnt = 0;
        end else begin
            bit in_door;
            in_door = (m_mode == 0 && m_st == 3);
            if (m_mode == 0) begin
                if (fire_alarm) begin
                    m_mode = 1; m_st = 0;
                    m_fs = (cur_floor > 1) ? 0 : 1;
                end else begin
                    case (m_st)
                        0: m_st = (req_floor > cur_floor) ? 1 : (req_floor < cur_floor) ? 2 : 0;
                        1: m_st = (req_floor > cur_floor) ? 1 : 3;
                        2: m_st = (req_floor < cur_floor) ? 2 : 3;
                        default: m_st = (m_cnt == DW) ? 0 : 3;
                    endcase
                end
            end else begin
                if (m_fs == 1 && !fire_alarm) begin
                    m_mode = 0; m_st = 0;
                end else if (m_fs == 0 && cur_floor <= 1) begin
                    m_fs = 1;
                end
            end
            if (!in_door) m_cnt = 0;
            else if (sec_tick && m_cnt < DW) m_cnt++;
        end
    end

    // per-cycle comparison against the reference, away from the rising edge
    always @(negedge clk) begin
        if (chk_on) begin
            string tag;
            if (m_mode == 1) tag = "R6";
            else if (m_st == 0) tag = "R2";
            else if (m_st == 3) tag = "R4";
            else tag = "R3";
            check(tag, {go_up, go_down, door_open, dwell_start}, model_out());
            check("R5", {1'b0, 1'b0, 1'b0, door_open && (go_up || go_down)}, 4'b0000);
            if (dwell_start) run_len++;
            else begin
                if (run_len != 0) last_run = run_len;
                run_len = 0;
            end
        end
    end

    // tick generator and simple car plant, driven at the falling edge
    always @(negedge clk) begin
        tick_ph = (tick_ph + 1) % tick_every;
        sec_tick <= (tick_ph == 0);
        if (plant_on && (go_up || go_down)) begin
            plant_cnt++;
            if (plant_cnt == 3) begin
                plant_cnt = 0;
                if (go_up && cur_floor != 4'd15) cur_floor <= cur_floor + 1'b1;
                if (go_down && cur_floor != 4'd0) cur_floor <= cur_floor - 1'b1;
            end
        end else plant_cnt = 0;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: first cycle after reset
        check("R1", {go_up, go_down, door_open, dwell_start}, 4'b0010);
        chk_on = 1'b1;
        cycles(5);

        // climb with a tick every cycle; dwell length measured at the ports
        plant_on = 1'b1;
        req_floor = 4'd6;
        cycles(70);
        check("R4", 4'(last_run), 4'(DW + 1));
        check("R8", 4'(last_run), 4'(DW + 1));

        // descend with sparse ticks, and change request during the door dwell
        tick_every = 4;
        req_floor = 4'd3;
        while (!dwell_start) @(negedge clk);
        req_floor = 4'd5;
        cycles(80);
        req_floor = 4'd1;
        cycles(80);

        // fire while climbing: descend to floor 1 and open
        tick_every = 1;
        req_floor = 4'd9;
        cycles(10);
        fire_alarm = 1'b1;
        @(negedge clk);
        check("R6", {go_up, go_down, door_open, dwell_start}, 4'b0100);
        cycles(60);
        check("R6", {go_up, go_down, door_open, dwell_start}, 4'b0010);
        cycles(10);
        fire_alarm = 1'b0;
        @(negedge clk);
        check("R7", {go_up, go_down, door_open, dwell_start}, 4'b0010);
        @(negedge clk);
        check("R7", {go_up, go_down, door_open, dwell_start}, 4'b1000);
        cycles(40);

        // alarm dropped during descent does not end the emergency
        fire_alarm = 1'b1;
        cycles(2);
        fire_alarm = 1'b0;
        cycles(2);
        check("R7", {go_up, go_down, door_open, dwell_start}, 4'b0100);
        cycles(60);

        // alarm at floor 1: door opens without descent
        plant_on = 1'b0;
        cur_floor = 4'd1;
        req_floor = 4'd1;
        cycles(20);
        fire_alarm = 1'b1;
        @(negedge clk);
        check("R6", {go_up, go_down, door_open, dwell_start}, 4'b0010);
        req_floor = 4'd7;
        cycles(5);
        check("R6", {go_up, go_down, door_open, dwell_start}, 4'b0010);
        fire_alarm = 1'b0;
        cycles(3);

        // alarm during door dwell
        req_floor = 4'd1;
        cycles(3);
        cur_floor = 4'd4;
        req_floor = 4'd4;
        cycles(2);
        req_floor = 4'd5;
        cycles(2);
        cur_floor = 4'd5;
        cycles(3);
        fire_alarm = 1'b1;
        cycles(3);
        fire_alarm = 1'b0;
        cycles(5);

        chk_on = 1'b0;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule